// File: doc/BRIEF.md
# Sum-of-Products Term Plane

This block is the AND plane in front of one logic block of a small programmable fabric. It takes a bus of routed input signals and forms the true and the inverted copy of every one of them. Each product-term row in a configuration store then picks any subset of those literals. A row's term is the logical AND of the literals it has picked. The terms are built in combinational logic straight from the inputs. Only the configuration store is clocked.

The rows are split by role. Rows 0 to 79 are general-purpose terms, and they go uninverted to the macrocell side. Rows 80 to 83 are output-enable terms. The first pair of these serves the upper eight I/O cells and the second pair serves the lower eight. Each cell has its own selection bit that picks one term of its pair. Rows 84, 85 and 86 drive the asynchronous set, the asynchronous reset and the term-derived clock. Each special row stores an inversion bit. When that bit is set, an AND of inverted literals acts as an OR of the true signals. Software loads one row per clock through a write port. The port carries a row index, 72 literal-enable bits and the inversion bit.

Top module: `sop_plane`

## Requirements
- R1: Literal-enable bit 2k of a row selects input k true, and bit 2k+1 selects input k inverted. A row's term is 1 exactly when every literal it selects is 1.
- R2: A row with no literal-enable bit set gives a term of 0.
- R3: A row that selects both the true and the inverted literal of the same input gives a term of 0, whatever the inputs are.
- R4: A write with row index 0 to 86 replaces that row's enable bits and its inversion bit. The new contents take effect at the clock edge that captures the write.
- R5: A write with row index 87 or above changes no row and no output.
- R6: Reset clears every row and every inversion bit. While reset is held, and after it is released, every output is 0.
- R7: Rows 0 to 79 drive gp_o[79:0] bit for bit. Their inversion bits have no effect.
- R8: I/O cells 8 to 15 take their output enable from row 80 when their oe_pick bit is 0 and from row 81 when it is 1. Cells 0 to 7 use rows 82 and 83 in the same way. Each of these four terms is XORed with its row's inversion bit.
- R9: aset_o, areset_o and ptclk_o are rows 84, 85 and 86, each XORed with its row's inversion bit. An unused inverted row therefore gives 1.
- R10: The outputs follow in_i and oe_pick with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst | input | 1 | Asynchronous active-high reset, clears the configuration |
| in_i | input | 36 | Routed input signals |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 7 | Row index of the write |
| wr_lits | input | 72 | Literal-enable bits for the row |
| wr_inv | input | 1 | Inversion bit for the row |
| oe_pick | input | 16 | Per-cell choice between the two enable terms of its half |
| gp_o | output | 80 | General-purpose product terms |
| oe_o | output | 16 | Output enable for each I/O cell |
| aset_o | output | 1 | Asynchronous set term |
| areset_o | output | 1 | Asynchronous reset term |
| ptclk_o | output | 1 | Term-derived clock |

## Verification
A row write takes effect at the clock edge that captures it. A change on in_i or oe_pick has no latency at all. The bench therefore drives every stimulus on a falling edge. When a row write is involved, it lets the following rising edge capture it. It then compares the outputs one nanosecond after the new inputs are applied, against a value computed from its own copy of the rows. A design that put a register anywhere on the path from the inputs would show the old value at that point and fail the check.

// File: rtl/sop_pkg.sv
package sop_pkg;
    parameter int unsigned SOP_INPUTS = 36;
    parameter int unsigned SOP_TERMS  = 87;
    parameter int unsigned SOP_GP     = 80;
    parameter int unsigned SOP_IO     = 16;
    parameter int unsigned SOP_ROW_W  = 7;

    // Offsets of the special rows after the general-purpose block
    parameter int unsigned OFS_OE_UP0 = 0;
    parameter int unsigned OFS_OE_UP1 = 1;
    parameter int unsigned OFS_OE_LO0 = 2;
    parameter int unsigned OFS_OE_LO1 = 3;
    parameter int unsigned OFS_SET    = 4;
    parameter int unsigned OFS_RESET  = 5;
    parameter int unsigned OFS_CLOCK  = 6;
    parameter int unsigned N_SPECIAL  = 7;
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
    parameter int unsigned TERMS = sop_pkg::SOP_TERMS,
    parameter int unsigned LITS  = 2 * sop_pkg::SOP_INPUTS,
    parameter int unsigned ROW_W = sop_pkg::SOP_ROW_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ROW_W-1:0]           wr_row,
    input  logic [LITS-1:0]            wr_lits,
    input  logic                       wr_inv,
    output logic [TERMS-1:0][LITS-1:0] mask_o,
    output logic [TERMS-1:0]           inv_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(TERMS - 1);

    typedef struct packed {
        logic [TERMS-1:0][LITS-1:0] mask;
        logic [TERMS-1:0]           inv;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic row_ok;

    always_comb begin
        cfg_d  = cfg_q;
        row_ok = (wr_row <= LAST_ROW);
        if (wr_en && row_ok) begin
            cfg_d.mask[wr_row] = wr_lits;
            cfg_d.inv[wr_row]  = wr_inv;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign mask_o = cfg_q.mask;
    assign inv_o  = cfg_q.inv;

    // R4
    row_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_row <= LAST_ROW) |=> (cfg_q.mask[$past(wr_row)] == $past(wr_lits)));

    // R5
    ign_hi_row_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_row > LAST_ROW) |=> $stable(cfg_q));
endmodule

// File: rtl/sop_term.sv
module sop_term #(
    parameter int unsigned INPUTS = sop_pkg::SOP_INPUTS
) (
    input  logic [INPUTS-1:0]   in_i,
    input  logic [2*INPUTS-1:0] mask_i,
    output logic                term_o
);
    localparam int unsigned LITS = 2 * INPUTS;

    logic [LITS-1:0]   lit;
    logic [INPUTS-1:0] use_t, use_c;

    for (genvar k = 0; k < INPUTS; k++) begin : g_lit
        assign lit[2*k]   = in_i[k];
        assign lit[2*k+1] = ~in_i[k];
        assign use_t[k]   = mask_i[2*k];
        assign use_c[k]   = mask_i[2*k+1];
    end

    logic any_sel, clash, hit;

    always_comb begin
        any_sel = |mask_i;
        clash   = |(use_t & use_c);
        hit     = &(lit | ~mask_i);
        term_o  = any_sel & ~clash & hit;
    end
endmodule

// File: rtl/sop_router.sv
module sop_router #(
    parameter int unsigned TERMS = sop_pkg::SOP_TERMS,
    parameter int unsigned GP    = sop_pkg::SOP_GP,
    parameter int unsigned IO    = sop_pkg::SOP_IO
) (
    input  logic [TERMS-1:0] terms_i,
    input  logic [TERMS-1:0] inv_i,
    input  logic [IO-1:0]    oe_pick_i,
    output logic [GP-1:0]    gp_o,
    output logic [IO-1:0]    oe_o,
    output logic             aset_o,
    output logic             areset_o,
    output logic             ptclk_o
);
    import sop_pkg::*;

    localparam int unsigned HALF = IO / 2;

    logic [N_SPECIAL-1:0] spec;

    always_comb begin
        gp_o = terms_i[GP-1:0];
        spec = terms_i[GP +: N_SPECIAL] ^ inv_i[GP +: N_SPECIAL];
        aset_o   = spec[OFS_SET];
        areset_o = spec[OFS_RESET];
        ptclk_o  = spec[OFS_CLOCK];
    end

    for (genvar c = 0; c < IO; c++) begin : g_cell
        if (c >= HALF) begin : g_up
            assign oe_o[c] = oe_pick_i[c] ? spec[OFS_OE_UP1] : spec[OFS_OE_UP0];
        end else begin : g_lo
            assign oe_o[c] = oe_pick_i[c] ? spec[OFS_OE_LO1] : spec[OFS_OE_LO0];
        end
    end
endmodule

// File: rtl/sop_plane.sv
module sop_plane #(
    parameter int unsigned INPUTS = sop_pkg::SOP_INPUTS,
    parameter int unsigned TERMS  = sop_pkg::SOP_TERMS,
    parameter int unsigned GP     = sop_pkg::SOP_GP,
    parameter int unsigned IO     = sop_pkg::SOP_IO,
    parameter int unsigned ROW_W  = sop_pkg::SOP_ROW_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [INPUTS-1:0]     in_i,
    input  logic                  wr_en,
    input  logic [ROW_W-1:0]      wr_row,
    input  logic [2*INPUTS-1:0]   wr_lits,
    input  logic                  wr_inv,
    input  logic [IO-1:0]         oe_pick,
    output logic [GP-1:0]         gp_o,
    output logic [IO-1:0]         oe_o,
    output logic                  aset_o,
    output logic                  areset_o,
    output logic                  ptclk_o
);
    localparam int unsigned LITS = 2 * INPUTS;

    logic [TERMS-1:0][LITS-1:0] mask;
    logic [TERMS-1:0]           inv;
    logic [TERMS-1:0]           terms;

    sop_cfg_store #(.TERMS(TERMS), .LITS(LITS), .ROW_W(ROW_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_row (wr_row),
        .wr_lits(wr_lits),
        .wr_inv (wr_inv),
        .mask_o (mask),
        .inv_o  (inv)
    );

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        sop_term #(.INPUTS(INPUTS)) u_term (
            .in_i  (in_i),
            .mask_i(mask[t]),
            .term_o(terms[t])
        );
    end

    sop_router #(.TERMS(TERMS), .GP(GP), .IO(IO)) u_route (
        .terms_i  (terms),
        .inv_i    (inv),
        .oe_pick_i(oe_pick),
        .gp_o     (gp_o),
        .oe_o     (oe_o),
        .aset_o   (aset_o),
        .areset_o (areset_o),
        .ptclk_o  (ptclk_o)
    );

    // R6
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gp_o == '0 && oe_o == '0 && !aset_o && !areset_o && !ptclk_o));

    // R10
    no_spurious_change_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(in_i) && $stable(oe_pick) && !$past(wr_en))
        |-> $stable({gp_o, oe_o, aset_o, areset_o, ptclk_o}));
endmodule

// File: tb/sop_plane_test.sv
module sop_plane_test;
    localparam int NI = 36;
    localparam int NT = 87;
    localparam int NL = 72;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] in_i = '0;
    logic          wr_en = 1'b0;
    logic [6:0]    wr_row = '0;
    logic [NL-1:0] wr_lits = '0;
    logic          wr_inv = 1'b0;
    logic [15:0]   oe_pick = '0;
    logic [79:0]   gp_o;
    logic [15:0]   oe_o;
    logic          aset_o, areset_o, ptclk_o;

    always #10 clk = ~clk;

    sop_plane uut (
        .clk(clk), .rst(rst), .in_i(in_i), .wr_en(wr_en), .wr_row(wr_row),
        .wr_lits(wr_lits), .wr_inv(wr_inv), .oe_pick(oe_pick), .gp_o(gp_o),
        .oe_o(oe_o), .aset_o(aset_o), .areset_o(areset_o), .ptclk_o(ptclk_o)
    );

    logic [NL-1:0] m_mask [NT];
    logic          m_inv  [NT];

    typedef struct {
        logic [98:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  probe_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    function automatic logic mterm(int t, logic [NI-1:0] x);
        if (m_mask[t] == '0) return 1'b0;
        for (int k = 0; k < NI; k++)
            if (m_mask[t][2*k] && m_mask[t][2*k+1]) return 1'b0;
        for (int k = 0; k < NI; k++) begin
            if (m_mask[t][2*k] && !x[k]) return 1'b0;
            if (m_mask[t][2*k+1] && x[k]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [98:0] mout(logic [NI-1:0] x);
        logic [79:0] g;
        logic [15:0] o;
        logic [6:0]  s;
        for (int t = 0; t < 80; t++) g[t] = mterm(t, x);
        for (int i = 0; i < 7; i++) s[i] = mterm(80 + i, x) ^ m_inv[80 + i];
        for (int c = 0; c < 16; c++) begin
            if (c >= 8) o[c] = oe_pick[c] ? s[1] : s[0];
            else        o[c] = oe_pick[c] ? s[3] : s[2];
        end
        return {g, o, s[4], s[5], s[6]};
    endfunction

    task automatic clear_model();
        for (int t = 0; t < NT; t++) begin
            m_mask[t] = '0;
            m_inv[t]  = 1'b0;
        end
    endtask

    task automatic probe(input logic [NI-1:0] x, input string tag);
        item_t it;
        @(negedge clk);
        in_i   = x;
        it.exp = mout(x);
        it.tag = tag;
        q.push_back(it);
        ->probe_ev;
        #2;
    endtask

    task automatic write_row(input int row, input logic [NL-1:0] lits, input logic inv);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_row  = 7'(row);
        wr_lits = lits;
        wr_inv  = inv;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (row < NT && !rst) begin
            m_mask[row] = lits;
            m_inv[row]  = inv;
        end
    endtask

    initial begin
        forever begin
            item_t it;
            logic [98:0] got;
            @(probe_ev);
            #1;
            it  = q.pop_front();
            got = {gp_o, oe_o, aset_o, areset_o, ptclk_o};
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s got=%h exp=%h", it.tag, got, it.exp);
            end
        end
    end

    initial begin
        logic [NL-1:0] all_true;
        clear_model();
        all_true = '0;
        for (int k = 0; k < NI; k++) all_true[2*k] = 1'b1;
        probe(36'h0_0000_0000, "R6 reset held zeros");
        @(negedge clk); rst = 1'b0;
        probe(36'hF_FFFF_FFFF, "R6 after release zeros");
        // R1 R4: row0 = in0 & ~in1
        write_row(0, 72'h9, 1'b0);
        probe(36'h1, "R1 in0&~in1 true");
        probe(36'h3, "R10 in1 high drops term");
        probe(36'h0, "R1 in0 low");
        // R2 R7: empty row with inversion bit
        write_row(5, '0, 1'b1);
        probe(36'h5, "R2 R7 empty row stays 0");
        // R3: both literals of input 2
        write_row(6, 72'h30, 1'b0);
        probe(36'h4, "R3 clash in2=1");
        probe(36'h0, "R3 clash in2=0");
        // R1 wide AND
        write_row(79, all_true, 1'b0);
        probe(36'hF_FFFF_FFFF, "R1 wide AND all ones");
        probe(36'hF_FFFF_FFFE, "R1 wide AND one zero");
        // R4 overwrite row 0 with ~in0
        write_row(0, 72'h2, 1'b0);
        probe(36'h0, "R4 overwrite row0");
        // R8 output enables
        oe_pick = 16'h0F0F;
        write_row(80, 72'h1, 1'b0);
        write_row(81, 72'h4, 1'b1);
        write_row(82, 72'h10, 1'b0);
        write_row(83, 72'h40, 1'b0);
        probe(36'h0, "R8 oe pattern a");
        probe(36'h5, "R8 oe pattern b");
        probe(36'hA, "R8 oe pattern c");
        oe_pick = 16'hF0F0;
        probe(36'hF, "R8 R10 oe after pick change");
        // R9 specials
        write_row(84, 72'hA, 1'b1);
        write_row(86, '0, 1'b1);
        probe(36'h0, "R9 set OR both low");
        probe(36'h2, "R9 set OR in1 high");
        probe(36'h1, "R9 set OR in0 high");
        // R5 out-of-range writes
        write_row(87, {NL{1'b1}}, 1'b1);
        write_row(127, {NL{1'b1}}, 1'b1);
        probe(36'h1, "R5 high rows ignored");
        // R6 reset mid-run
        @(negedge clk); rst = 1'b1;
        clear_model();
        probe(36'h3, "R6 reset clears config");
        @(negedge clk); rst = 1'b0;
        probe(36'h0, "R6 zeros after second release");
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule